// File: doc/BRIEF.md
# Selectable 96/112 Clock Divider

This block is the feedback divider of a frequency synthesizer. It takes a fast clock and makes an output clock whose period is 96 or 112 input cycles, picked by a one-bit select. With either a 2.496 GHz input divided by 96 or a 2.912 GHz input divided by 112, the output runs at 26 MHz. The output always has a 50% duty cycle.

The ratio is built from three stages in cascade: 8 × (6 or 7) × 2. A divide-by-8 prescaler feeds a middle stage. The middle stage holds a divide-by-6 counter and a divide-by-7 counter; both count all the time, and a 2:1 multiplexer picks which one's wrap drives the last stage. The last stage is a toggle flip-flop, and it is what evens out the odd ratio. All flip-flops run on the input clock, and stage enables replace derived clocks.

The select is captured only at a rising edge of the output. Each rise-to-rise period therefore uses one ratio only. A one-cycle pulse marks each rising edge of the output.

Top module: `sel_clk_div`

## Requirements
- R1: With the applied select equal to 0, the output stays high for 48 input cycles and then low for 48 input cycles, which gives a period of 96.
- R2: With the applied select equal to 1, each output phase lasts 56 input cycles, which gives a period of 112.
- R3: The high time and the low time are equal in every output period, for both ratios.
- R4: The select takes effect only at a rising edge of `clk_out`. A change of `sel` during a high phase or a low phase leaves the rest of the current rise-to-rise period at the old ratio. The next period uses the new ratio.
- R5: While `rst_n` is low, `clk_out` and `tc` are 0. After reset is released, with `sel` held steady, the first rising edge of `clk_out` comes after half the selected period: 48 cycles for `sel`=0 and 56 cycles for `sel`=1.
- R6: `tc` is 1 for exactly the first input cycle of each high phase of `clk_out`. It is 0 in every other cycle.
- R7: A `sel` pulse that starts and ends inside one output period, before the next rising edge, has no effect on any output phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; every flip-flop runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Ratio select: 0 divides by 96, 1 divides by 112 |
| clk_out | output | 1 | Divided clock with 50% duty cycle |
| tc | output | 1 | One-cycle pulse on the first cycle of each high phase |

## Verification
The bench times every high run and every low run of the output in input cycles. It compares each run with 8 × 6 or 8 × 7, worked out from the select that was applied. It changes the select partway through a high phase and partway through a low phase. A divider that applied the change at any wrap would show one period that mixes a 48 phase with a 56 phase. A select pulse that comes and goes within one period would, in a design that sampled it at the wrong time, stretch a phase to 56. A reset given mid-phase with the other ratio selected checks that the first half period after release follows the new select. A wrong `tc` would show up as a pulse that is missing, too long, or placed in the wrong cycle.

// File: rtl/sel_clk_div.sv
module sel_clk_div #(
  parameter int PRE_DIV = 8,
  parameter int MID_A   = 6,
  parameter int MID_B   = 7
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out,
  output logic tc
);
  localparam int PW = $clog2(PRE_DIV);
  localparam int AW = $clog2(MID_A);
  localparam int BW = $clog2(MID_B);
  localparam int HW = $clog2(PRE_DIV * MID_B * 2);

  logic [PW-1:0] pre;
  logic [AW-1:0] cnt_a;
  logic [BW-1:0] cnt_b;
  logic sel_q, run, clk_q, tc_q;

  wire pre_end = pre == PW'(PRE_DIV - 1);
  wire a_end   = pre_end && (cnt_a == AW'(MID_A - 1));
  wire b_end   = pre_end && (cnt_b == BW'(MID_B - 1));
  wire mid_end = sel_q ? b_end : a_end;
  wire rise    = mid_end && !clk_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      cnt_a <= '0;
      cnt_b <= '0;
      sel_q <= 1'b0;
      run   <= 1'b0;
      clk_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      pre <= pre_end ? '0 : pre + 1'b1;
      if (mid_end) begin
        cnt_a <= '0;
        cnt_b <= '0;
      end else if (pre_end) begin
        cnt_a <= a_end ? '0 : cnt_a + 1'b1;
        cnt_b <= b_end ? '0 : cnt_b + 1'b1;
      end
      if (!run || rise) sel_q <= sel;
      if (rise) run <= 1'b1;
      clk_q <= clk_q ^ mid_end;
      tc_q  <= rise;
    end
  end

  assign clk_out = clk_q;
  assign tc      = tc_q;

  logic clk_d;
  logic [HW-1:0] hcnt;
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      hcnt  <= '0;
    end else begin
      clk_d <= clk_q;
      hcnt  <= (clk_q != clk_d) ? HW'(1) : hcnt + 1'b1;
    end
  end

  assert_half_len_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
    (clk_q != clk_d) |-> (int'(hcnt) == ($past(sel_q) ? PRE_DIV * MID_B : PRE_DIV * MID_A)));

  assert_sel_hold_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($past(run) && !tc_q) |-> $stable(sel_q));

  assert_tc_rise_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    tc_q == $rose(clk_q));

  assert_reset_low_R5: assert property (@(posedge clk_in)
    !rst_n |-> (!clk_q && !tc_q));

  assert_edge_on_prescale_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(clk_q) |-> ($past(pre) == PW'(PRE_DIV - 1)));
endmodule

// File: tb/sel_clk_div_tb.sv
module sel_clk_div_tb;
  logic clk_in = 1'b0;
  logic rst_n, sel;
  logic clk_out, tc;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_in = ~clk_in;

  sel_clk_div u_dut (.clk_in(clk_in), .rst_n(rst_n), .sel(sel), .clk_out(clk_out), .tc(tc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_len(input logic lvl, output int n, output int tcbad);
    n = 0;
    tcbad = 0;
    while (clk_out == lvl && n < 2000) begin
      if (lvl && n == 0 && tc !== 1'b1) tcbad++;
      else if (!(lvl && n == 0) && tc !== 1'b0) tcbad++;
      n++;
      @(negedge clk_in);
    end
  endtask

  task automatic phase(input logic lvl, input int exp, input string req);
    int n, tb;
    run_len(lvl, n, tb);
    chk(n == exp, req, n, exp);
    chk(tb == 0, "R6 tc pulse", tb, 0);
  endtask

  task automatic partial(input logic lvl, input int pre, input logic nsel,
                         input int exp, input string req);
    int n, tb;
    repeat (pre) @(negedge clk_in);
    sel = nsel;
    run_len(lvl, n, tb);
    chk(pre + n == exp, req, pre + n, exp);
  endtask

  initial begin
    rst_n = 1'b1;
    sel = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk_in);
    chk(clk_out == 1'b0, "R5 reset clk_out", int'(clk_out), 0);
    chk(tc == 1'b0, "R5 reset tc", int'(tc), 0);
    rst_n = 1'b1;
    phase(1'b0, 48, "R5 first low sel0");
    for (int i = 0; i < 3; i++) begin
      phase(1'b1, 48, "R1 high sel0");
      phase(1'b0, 48, "R3 low sel0");
    end
    partial(1'b1, 10, 1'b1, 48, "R4 high after change");
    phase(1'b0, 48, "R4 low keeps old ratio");
    phase(1'b1, 56, "R2 high sel1");
    phase(1'b0, 56, "R3 low sel1");
    partial(1'b1, 20, 1'b1, 56, "R2 high sel1 steady");
    partial(1'b0, 5, 1'b0, 56, "R4 low after change");
    phase(1'b1, 48, "R4 new ratio high");
    phase(1'b0, 48, "R1 low sel0");
    repeat (5) @(negedge clk_in);
    sel = 1'b1;
    repeat (3) @(negedge clk_in);
    partial(1'b1, 0, 1'b0, 40, "R7 remaining high");
    phase(1'b0, 48, "R7 low");
    phase(1'b1, 48, "R7 high");
    repeat (7) @(negedge clk_in);
    rst_n = 1'b0;
    sel = 1'b1;
    @(negedge clk_in);
    chk(clk_out == 1'b0, "R5 mid reset clk_out", int'(clk_out), 0);
    chk(tc == 1'b0, "R5 mid reset tc", int'(tc), 0);
    rst_n = 1'b1;
    phase(1'b0, 56, "R5 first low sel1");
    phase(1'b1, 56, "R2 high after reset");
    phase(1'b0, 56, "R3 low after reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule